// File: doc/BRIEF.md
# Column Hit Sparsifier

This block turns one column of pixel hits, delivered by a readout scanner as an 8-bit vector, into a dense list of fully addressed and time-stamped hit words. All words for the column are produced in one clock. Each set bit becomes a word that carries the pixel row, the column position inside the macro-pixel, the macro-column address and a time stamp. The words sit on consecutive output lanes starting at lane 0. A count of 0 to 8 tells a downstream buffer how many lanes to take.

The time stamp comes from an internal counter of bunch-crossing windows, which advances on each bunch-crossing edge. When an edge arrives, the hits already in the matrix are frozen and belong to the window that has just closed. For that reason the words carry the stamp of that closed window, held in a separate register, and not the stamp of the window now open. All outputs are registered, so results appear one cycle after the column is presented.

Top module: `col_sparsifier`

## Requirements
- R1: Each 17-bit lane word is laid out as bit 16 valid, bits 15:13 pixel row, bits 12:11 column within the macro-pixel, bits 10:8 macro-column address, and bits 7:0 time stamp. Lane j occupies bits 17*j+16 down to 17*j of `word_bus`.
- R2: When the strobe is high, `hit_count` equals the number of set bits in `hit_vec`, from 0 to 8.
- R3: The hits are placed in ascending row order on lanes 0 to N-1, where N is the hit count.
- R4: Every lane at or above the hit count outputs an all-zero word, so its valid bit is 0.
- R5: A cycle with the strobe low produces a count of 0 and all-zero lanes, whatever `hit_vec` holds.
- R6: The outputs change only at the clock edge that samples the inputs, giving one cycle of latency.
- R7: The window counter advances by one on each cycle with `bc_edge` high and wraps modulo 256.
- R8: Words carry the frozen stamp, which is the counter value just before the most recent bunch-crossing edge. The frozen stamp is 0 before any edge.
- R9: If a column is strobed in the same cycle as a bunch-crossing edge, its words carry the frozen stamp as it was before that edge.
- R10: While reset is high, `hit_count` and `word_bus` are 0, and both the window counter and the frozen stamp restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_edge | input | 1 | Bunch-crossing edge: closes the current window |
| col_strobe | input | 1 | The column on `hit_vec` is valid this cycle |
| hit_vec | input | 8 | Hit pattern of the column, bit r is row r |
| pix_col | input | 2 | Column position inside the macro-pixel |
| mc_addr | input | 3 | Macro-column address |
| word_bus | output | 136 | Eight packed 17-bit hit words |
| hit_count | output | 4 | Number of valid lanes, 0 to 8 |

## Verification
Two functions can act in the same cycle: packing a strobed column and advancing the window on a bunch-crossing edge. The bench raises `bc_edge` together with the strobe on every fifth column of a full sweep of all 256 hit patterns. It then checks that each word carries the stamp from before that edge, and that the following columns carry the new frozen stamp. A run of more than 256 edges is used to test the counter wrap.

// File: rtl/sparse_pkg.sv
package sparse_pkg;
  localparam int unsigned ROWS_D = 8;
  localparam int unsigned COLW_D = 2;
  localparam int unsigned MCW_D  = 3;
  localparam int unsigned TSW_D  = 8;
endpackage

// File: rtl/ts_window.sv
module ts_window #(
  parameter int unsigned TSW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bc_edge,
  output logic [TSW-1:0] ts_frozen
);
  logic [TSW-1:0] ts_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_cur    <= '0;
      ts_frozen <= '0;
    end else if (bc_edge) begin
      ts_frozen <= ts_cur;
      ts_cur    <= ts_cur + TSW'(1);
    end
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    bc_edge |=> ts_frozen == $past(ts_cur) && ts_cur == TSW'($past(ts_cur) + TSW'(1))); // R7
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bc_edge |=> $stable(ts_cur) && $stable(ts_frozen)); // R8
endmodule

// File: rtl/hit_compactor.sv
module hit_compactor #(
  parameter int unsigned ROWS = 8,
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned CNTW = $clog2(ROWS+1)
) (
  input  logic               en,
  input  logic [ROWS-1:0]    hit_vec,
  output logic [ROWS*RW-1:0] lane_row,
  output logic [ROWS-1:0]    lane_vld,
  output logic [CNTW-1:0]    count
);
  always_comb begin
    int unsigned k;
    k        = 0;
    lane_row = '0;
    lane_vld = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (en && hit_vec[r]) begin
        lane_row[k*RW +: RW] = RW'(r);
        lane_vld[k]          = 1'b1;
        k                    = k + 1;
      end
    end
    count = CNTW'(k);
  end
endmodule

// File: rtl/col_sparsifier.sv
module col_sparsifier
  import sparse_pkg::*;
#(
  parameter int unsigned ROWS = ROWS_D,
  parameter int unsigned COLW = COLW_D,
  parameter int unsigned MCW  = MCW_D,
  parameter int unsigned TSW  = TSW_D,
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned CNTW = $clog2(ROWS+1),
  localparam int unsigned W    = 1 + RW + COLW + MCW + TSW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bc_edge,
  input  logic              col_strobe,
  input  logic [ROWS-1:0]   hit_vec,
  input  logic [COLW-1:0]   pix_col,
  input  logic [MCW-1:0]    mc_addr,
  output logic [ROWS*W-1:0] word_bus,
  output logic [CNTW-1:0]   hit_count
);
  logic [TSW-1:0]     ts_frozen;
  logic [ROWS*RW-1:0] lane_row;
  logic [ROWS-1:0]    lane_vld;
  logic [CNTW-1:0]    cnt_c;

  ts_window #(.TSW(TSW)) u_ts (
    .clk(clk), .rst(rst), .bc_edge(bc_edge), .ts_frozen(ts_frozen)
  );

  hit_compactor #(.ROWS(ROWS)) u_cmp (
    .en(col_strobe), .hit_vec(hit_vec),
    .lane_row(lane_row), .lane_vld(lane_vld), .count(cnt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_count <= '0;
    else     hit_count <= cnt_c;
  end

  for (genvar j = 0; j < ROWS; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || !lane_vld[j]) word_bus[j*W +: W] <= '0;
      else word_bus[j*W +: W] <= {1'b1, lane_row[j*RW +: RW], pix_col, mc_addr, ts_frozen};
    end

    AST_LANE_VALID: assert property (@(posedge clk) disable iff (rst)
      word_bus[j*W + W-1] == (CNTW'(j) < hit_count)); // R4

    if (j > 0) begin : g_ord
      AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
        word_bus[j*W + W-1] |->
          word_bus[j*W + W-2 -: RW] > word_bus[(j-1)*W + W-2 -: RW]); // R3
    end
  end

  AST_COUNT_POP: assert property (@(posedge clk) disable iff (rst)
    $past(col_strobe && !rst) |-> hit_count == CNTW'($countones($past(hit_vec)))); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(col_strobe) |-> hit_count == '0 && word_bus == '0); // R5
endmodule

// File: tb/col_sparsifier_bench.sv
module col_sparsifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 17;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst, bc_edge, col_strobe;
  logic [7:0] hit_vec;
  logic [1:0] pix_col;
  logic [2:0] mc_addr;
  logic [NL*WW-1:0] word_bus;
  logic [3:0] hit_count;

  int n_vec = 0;
  int n_bad = 0;
  int m_cur = 0;
  int m_frz = 0;
  logic [NL*WW-1:0] prev_bus = '0;
  logic [3:0]       prev_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_sparsifier u_col_sparsifier (
    .clk(clk), .rst(rst), .bc_edge(bc_edge), .col_strobe(col_strobe),
    .hit_vec(hit_vec), .pix_col(pix_col), .mc_addr(mc_addr),
    .word_bus(word_bus), .hit_count(hit_count)
  );

  task automatic check(string tag, logic [NL*WW-1:0] eb, logic [3:0] ec);
    n_vec++;
    if (word_bus !== eb || hit_count !== ec) begin
      n_bad++;
      $display("FAIL %s: bus=%h cnt=%0d expected bus=%h cnt=%0d", tag, word_bus, hit_count, eb, ec);
    end
  endtask

  task automatic apply(logic s, logic [7:0] h, logic [1:0] c, logic [2:0] m, logic e, string tag);
    logic [NL*WW-1:0] eb;
    int k;
    eb = '0;
    k  = 0;
    for (int r = 0; r < 8; r++) begin
      if (s && h[r]) begin
        eb = eb | ((NL*WW)'((1 << 16) + (r << 13) + (int'(c) << 11) + (int'(m) << 8) + m_frz) << (WW*k));
        k++;
      end
    end
    col_strobe = s; hit_vec = h; pix_col = c; mc_addr = m; bc_edge = e;
    #1;
    check("R6", prev_bus, prev_cnt);
    if (e) begin
      m_frz = m_cur;
      m_cur = (m_cur + 1) % 256;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, eb, 4'(k));
    prev_bus = eb;
    prev_cnt = 4'(k);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bc_edge = 1'b1; col_strobe = 1'b1; hit_vec = 8'hFF;
    pix_col = '0; mc_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", '0, '0);
    rst = 1'b0;
    bc_edge = 1'b0; col_strobe = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // R8: stamp 0 before any edge, then frozen value after edges
    apply(1'b1, 8'h81, 2'd3, 3'd6, 1'b0, "R8");
    apply(1'b0, 8'h00, 2'd0, 3'd0, 1'b1, "R8");
    apply(1'b1, 8'h18, 2'd1, 3'd2, 1'b1, "R9");
    apply(1'b1, 8'h42, 2'd2, 3'd1, 1'b0, "R8");

    // R2 R3 R4 sweep, with R9 collisions on every fifth column
    for (int h = 0; h < 256; h++)
      apply(1'b1, 8'(h), 2'(h), 3'(h >> 2), (h % 5) == 0, (h % 5) == 0 ? "R9" : "R2,R3,R4");

    // R5: strobe low, hits ignored
    for (int h = 1; h < 256; h += 17)
      apply(1'b0, 8'(h), 2'(h), 3'(h), (h % 3) == 0, "R5");

    // R1: field positions for a single hit at row 2
    apply(1'b1, 8'h04, 2'd1, 3'd5, 1'b0, "R1");
    n_vec++;
    if (word_bus[16] !== 1'b1 || word_bus[15:13] !== 3'd2 || word_bus[12:11] !== 2'd1 ||
        word_bus[10:8] !== 3'd5 || word_bus[7:0] !== 8'(m_frz)) begin
      n_bad++;
      $display("FAIL R1: word=%h expected fields v=1 row=2 col=1 mc=5 ts=%0d", word_bus[16:0], m_frz);
    end

    // R7: more than 256 edges, then a column to observe the wrapped stamp
    for (int i = 0; i < 300; i++)
      apply(1'b0, 8'hA5, 2'd0, 3'd0, 1'b1, "R7");
    apply(1'b1, 8'hC3, 2'd2, 3'd7, 1'b0, "R7");
    apply(1'b1, 8'hFF, 2'd3, 3'd3, 1'b1, "R7");
    apply(1'b1, 8'h01, 2'd0, 3'd4, 1'b0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule